// File: doc/BRIEF.md
# External Interrupt Flag and Request Unit

This unit watches two active-low interrupt pins for an 8-bit CPU. For each pin, a mode bit chooses how the pin is detected. A 0 means level-sensitive: the pin is pending whenever it reads low. A 1 means falling-edge-sensitive: the pin is pending only when it goes from high to low between two samples. Each pin's pending flag sits next to its mode bit in a small control image. Software can write that image as a whole byte or one bit at a time.

An interrupt-enable byte holds a global gate and one local gate per input. Each cycle the unit checks which flags are both set and enabled. It picks the lowest-numbered such input and drives a registered request together with that input's fixed vector address. When the CPU acknowledges an edge-mode request, that input's flag clears. A level-mode flag stays set after an acknowledge. It is set again on every cycle the pin stays low.

Top module: `ext_irq_unit`

## Requirements
- R1: A synchronous active-high reset clears every mode bit, pending flag and enable bit. It drives `irq_req` and `irq_vec` to 0 and sets the stored previous pin level of each input to high.
- R2: With mode bit 0 (level), the input's flag is set at every clock edge at which its pin reads low. The flag and the request derived from it become visible after that same edge.
- R3: With mode bit 1 (edge), the flag is set only at an edge where the stored previous sample is high and the current pin reads low. A pin that stays low sets nothing more.
- R4: A byte write replaces the control image. The image bits are: bit 0 is the mode of input 0, bit 1 is the flag of input 0, bit 2 is the mode of input 1, and bit 3 is the flag of input 1.
- R5: A bit write to bit address 0x88, 0x89, 0x8A or 0x8B replaces image bit 0, 1, 2 or 3 respectively. A bit write to any other address changes nothing.
- R6: `irq_req` is 1 only when enable bit 7 (global) is set and some input has both its flag and its local enable set. The local enable is bit 0 for input 0 and bit 2 for input 1.
- R7: The vector is 0x0003 for input 0 and 0x0013 for input 1. `irq_vec` reads 0 when no request is raised.
- R8: When both inputs are pending and enabled, input 0 is the one presented.
- R9: An acknowledge while `irq_req` is 1 clears the presented input's flag if that input is in edge mode. In level mode the flag is left unchanged.
- R10: A hardware set in the same cycle as a software write to a flag wins, so the flag ends up 1.
- R11: An acknowledge while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 2 | Active-low interrupt pins; bit n belongs to input n |
| ctl_we | input | 1 | Byte write strobe for the control image |
| ctl_wdata | input | 8 | Byte write data; bits 3..0 are stored |
| bit_we | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit address of the bit write |
| bit_wdata | input | 1 | Bit write value |
| ien_we | input | 1 | Write strobe for the enable byte |
| ien_wdata | input | 8 | Enable byte; bit 7 global, bit 0 input 0, bit 2 input 1 |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| ctl_q | output | 4 | Control image: mode and flag of each input |
| irq_req | output | 1 | Registered request valid |
| irq_vec | output | 16 | Registered vector address of the presented input |

## Verification
If a pending flag or mode bit holds a wrong value, the error shows on `ctl_q` right after the clock edge that stored it. An enabled input also shows the wrong state on `irq_req` and `irq_vec` after that same edge. A wrong stored previous pin level is not visible directly. It shows up as a missing or extra flag set at the first falling pin after the fault, so the stimulus walks a pin through high, falling and held-low phases in edge mode. An acknowledge routed to the wrong input shows on the next `ctl_q` value.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned CH_N     = 2;
  localparam int unsigned CH_W     = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int unsigned CTL_W    = 2 * CH_N;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned GLB_BIT  = 7;
  localparam logic [VEC_W-1:0]  VEC_BASE = 16'h0003;
  localparam logic [VEC_W-1:0]  VEC_STEP = 16'h0010;
  localparam logic [BYTE_W-1:0] BIT_BASE = 8'h88;

  function automatic logic [VEC_W-1:0] vec_of(input int unsigned ch);
    return VEC_BASE + VEC_W'(VEC_STEP * ch);
  endfunction
endpackage

// File: rtl/ext_irq_chan.sv
module ext_irq_chan (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic mode_we,
  input  logic mode_wd,
  input  logic flag_we,
  input  logic flag_wd,
  input  logic ack_clr,
  output logic mode_q,
  output logic flag_q,
  output logic flag_d
);
  logic prev_q;
  logic fall;
  logic set_hw;

  assign fall   = prev_q & ~pin_n;
  assign set_hw = mode_q ? fall : ~pin_n;

  always_comb begin
    if (set_hw)                 flag_d = 1'b1;
    else if (flag_we)           flag_d = flag_wd;
    else if (ack_clr && mode_q) flag_d = 1'b0;
    else                        flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      mode_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      flag_q <= flag_d;
      if (mode_we) mode_q <= mode_wd;
    end
  end

  // R2
  level_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !pin_n) |=> flag_q);
  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && prev_q && !pin_n) |=> flag_q);
  // R3
  edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !(prev_q && !pin_n) && !flag_q && !flag_we) |=> !flag_q);
  // R9
  edge_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && ack_clr && !(prev_q && !pin_n) && !flag_we) |=> !flag_q);
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
#(
  parameter int unsigned N = CH_N,
  parameter int unsigned W = CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend_d,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [W-1:0]     irq_ch
);
  logic [W-1:0]     sel;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    sel   = '0;
    vec_d = '0;
    for (int ch = int'(N) - 1; ch >= 0; ch--) begin
      if (pend_d[ch]) begin
        sel   = W'(ch);
        vec_d = vec_of(ch);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_ch  <= '0;
    end else begin
      irq_req <= |pend_d;
      irq_vec <= vec_d;
      irq_ch  <= sel;
    end
  end

  // R7
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0));
  // R7
  busy_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec == vec_of(0) || irq_vec == vec_of(1)));
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_N-1:0]   pin_n,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] ctl_wdata,
  input  logic              bit_we,
  input  logic [BYTE_W-1:0] bit_addr,
  input  logic              bit_wdata,
  input  logic              ien_we,
  input  logic [BYTE_W-1:0] ien_wdata,
  input  logic              irq_ack,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [CH_N-1:0]   mode_q, flag_q, flag_d, loc_q, loc_d, pend_d;
  logic [CH_W-1:0]   irq_ch;
  logic              glb_q, glb_d;
  logic [BYTE_W-1:0] used_ien;
  logic              wdata_unused;

  always_comb begin
    used_ien = '0;
    used_ien[GLB_BIT] = 1'b1;
    for (int ch = 0; ch < int'(CH_N); ch++) used_ien[2*ch] = 1'b1;
  end
  assign wdata_unused = ^(ien_wdata & ~used_ien) ^ ^ctl_wdata[BYTE_W-1:CTL_W];

  assign glb_d = ien_we ? ien_wdata[GLB_BIT] : glb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q <= 1'b0;
      loc_q <= '0;
    end else begin
      glb_q <= glb_d;
      loc_q <= loc_d;
    end
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    localparam logic [BYTE_W-1:0] A_MODE = BIT_BASE + BYTE_W'(2 * ch);
    localparam logic [BYTE_W-1:0] A_FLAG = BIT_BASE + BYTE_W'(2 * ch + 1);
    logic hit_m, hit_f;

    assign hit_m     = bit_we && (bit_addr == A_MODE);
    assign hit_f     = bit_we && (bit_addr == A_FLAG);
    assign loc_d[ch] = ien_we ? ien_wdata[2*ch] : loc_q[ch];
    assign pend_d[ch] = flag_d[ch] & loc_d[ch] & glb_d;
    assign ctl_q[2*ch]   = mode_q[ch];
    assign ctl_q[2*ch+1] = flag_q[ch];

    ext_irq_chan i_chan (
      .clk     (clk),
      .rst     (rst),
      .pin_n   (pin_n[ch]),
      .mode_we (ctl_we | hit_m),
      .mode_wd (hit_m ? bit_wdata : ctl_wdata[2*ch]),
      .flag_we (ctl_we | hit_f),
      .flag_wd (hit_f ? bit_wdata : ctl_wdata[2*ch+1]),
      .ack_clr (irq_ack && irq_req && (irq_ch == CH_W'(ch))),
      .mode_q  (mode_q[ch]),
      .flag_q  (flag_q[ch]),
      .flag_d  (flag_d[ch])
    );
  end

  ext_irq_arb #(.N(CH_N), .W(CH_W)) i_arb (
    .clk     (clk),
    .rst     (rst),
    .pend_d  (pend_d),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .irq_ch  (irq_ch)
  );

  // R6
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (glb_q && |(flag_q & loc_q)));
  // R6
  req_due_chk: assert property (@(posedge clk) disable iff (rst)
    (glb_q && |(flag_q & loc_q)) |-> irq_req);
  // R8
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && flag_q[0] && loc_q[0]) |-> (irq_vec == vec_of(0)));
endmodule

// File: tb/test_ext_irq_unit.sv
module test_ext_irq_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  pin_n = 2'b11;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        bit_we = 1'b0;
  logic [7:0]  bit_addr = '0;
  logic        bit_wdata = 1'b0;
  logic        ien_we = 1'b0;
  logic [7:0]  ien_wdata = '0;
  logic        irq_ack = 1'b0;
  logic [3:0]  ctl_q;
  logic        irq_req;
  logic [15:0] irq_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ext_irq_unit i_ext_irq_unit (
    .clk(clk), .rst(rst), .pin_n(pin_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .bit_we(bit_we), .bit_addr(bit_addr), .bit_wdata(bit_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .irq_ack(irq_ack),
    .ctl_q(ctl_q), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  typedef struct packed {
    logic [1:0]  pins;
    logic        cw;
    logic [3:0]  cd;
    logic        ew;
    logic [7:0]  ed;
    logic        ack;
    logic [3:0]  ectl;
    logic        ereq;
    logic [15:0] evec;
  } row_t;

  // ctl image: bit0 mode0, bit1 flag0, bit2 mode1, bit3 flag1
  localparam int ROWS = 18;
  localparam row_t TBL [ROWS] = '{
    '{2'b11, 1'b0, 4'h0, 1'b1, 8'h85, 1'b0, 4'b0000, 1'b0, 16'h0000}, // R6 enables on
    '{2'b10, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b0010, 1'b1, 16'h0003}, // R2 level low
    '{2'b11, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 4'b0010, 1'b1, 16'h0003}, // R9 level ack keeps
    '{2'b11, 1'b1, 4'h0, 1'b0, 8'h00, 1'b0, 4'b0000, 1'b0, 16'h0000}, // R4 clear flags
    '{2'b11, 1'b1, 4'h5, 1'b0, 8'h00, 1'b0, 4'b0101, 1'b0, 16'h0000}, // R4 both edge
    '{2'b01, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b1101, 1'b1, 16'h0013}, // R3 R7 fall on 1
    '{2'b01, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 4'b0101, 1'b0, 16'h0000}, // R9 edge ack clears
    '{2'b01, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b0101, 1'b0, 16'h0000}, // R3 held low
    '{2'b00, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b0111, 1'b1, 16'h0003}, // R3 R7 fall on 0
    '{2'b11, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b0111, 1'b1, 16'h0003}, // R3 rise no change
    '{2'b01, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b1111, 1'b1, 16'h0003}, // R8 both pending
    '{2'b01, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 4'b1101, 1'b1, 16'h0013}, // R9 R8 ack input 0
    '{2'b01, 1'b0, 4'h0, 1'b1, 8'h05, 1'b0, 4'b1101, 1'b0, 16'h0000}, // R6 global off
    '{2'b01, 1'b0, 4'h0, 1'b1, 8'h84, 1'b0, 4'b1101, 1'b1, 16'h0013}, // R6 local 1 only
    '{2'b01, 1'b0, 4'h0, 1'b1, 8'h81, 1'b0, 4'b1101, 1'b0, 16'h0000}, // R6 local 0 only
    '{2'b01, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 4'b1101, 1'b0, 16'h0000}, // R11 idle ack
    '{2'b11, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'b1101, 1'b0, 16'h0000}, // R3 pins high
    '{2'b01, 1'b1, 4'h5, 1'b0, 8'h00, 1'b0, 4'b1101, 1'b0, 16'h0000}  // R10 hw beats write
  };

  task automatic check(input string req, input logic [3:0] ectl,
                       input logic ereq, input logic [15:0] evec);
    checks++;
    if (ctl_q !== ectl || irq_req !== ereq || irq_vec !== evec) begin
      fails++;
      $display("FAIL %s: ctl=%b req=%b vec=%h expected ctl=%b req=%b vec=%h",
               req, ctl_q, irq_req, irq_vec, ectl, ereq, evec);
    end
  endtask

  task automatic bit_step(input logic [7:0] addr, input logic val);
    bit_we = 1'b1; bit_addr = addr; bit_wdata = val;
    @(posedge clk); @(negedge clk);
    bit_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 4'b0000, 1'b0, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < ROWS; i++) begin
      pin_n = TBL[i].pins;
      ctl_we = TBL[i].cw; ctl_wdata = {4'h0, TBL[i].cd};
      ien_we = TBL[i].ew; ien_wdata = TBL[i].ed;
      irq_ack = TBL[i].ack;
      @(posedge clk); @(negedge clk);
      ctl_we = 1'b0; ien_we = 1'b0; irq_ack = 1'b0;
      check($sformatf("row %0d", i), TBL[i].ectl, TBL[i].ereq, TBL[i].evec);
    end

    // R5: clear mode of input 1 through bit address 0x8A
    bit_step(8'h8A, 1'b0);
    check("R5", 4'b1001, 1'b0, 16'h0000);
    // R5: address outside the image is ignored
    bit_step(8'h8C, 1'b1);
    check("R5", 4'b1001, 1'b0, 16'h0000);
    // R5: set flag of input 0 through bit address 0x89
    bit_step(8'h89, 1'b1);
    check("R5", 4'b1011, 1'b1, 16'h0003);

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 4'b0000, 1'b0, 16'h0000);
    rst = 1'b0;
    // R2: input 1 back in level mode with pin low
    @(posedge clk); @(negedge clk);
    check("R2", 4'b1000, 1'b0, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule